// File: doc/BRIEF.md
# Masked Data Watchpoint Unit

This block sits beside a core's load/store port and watches every data access for addresses, and optionally data values, that a debugger has armed. It has four independent comparators. Each holds a reference address, a reference data word and a small configuration field. A shared control register enables each comparator. The configuration field sets how many low address bits are ignored, which access kinds (loads, stores or both) qualify, and whether the address, the data or both must agree. Instruction fetches never reach this port and are never matched.

A hit in any enabled comparator sets that comparator's sticky status bit one cycle later. Any set status bit drives the halt request to the core. The debugger reads the status to see which comparator fired, then clears it by writing ones to the status register. All configuration goes through a small word-wide register bus with combinational read-back.

Register bus offsets (`cfg_addr`): 0x0 enable control (bit i enables comparator i); 0x1 status (bit i is comparator i, write 1 to clear); 0x4+i reference address of comparator i; 0x8+i configuration of comparator i; 0xC+i reference data of comparator i. The configuration word holds the mask count in bits [3:0], the access kind in bits [5:4] and the match selector in bits [7:6]. Upper bits read as zero.

Top module: `dwatch_unit`

## Requirements
- R1: After reset the enable, status, reference and configuration registers all read zero, `wp_match` is 0 and `halt_req` is low.
- R2: A comparator whose enable bit (control offset 0x0, bit i) is 0 never sets its status bit, even when the access would match.
- R3: A mask count N in configuration bits [3:0] (0 to 15) makes the address comparison ignore the lowest N address bits. A count of 0 requires an exact address.
- R4: The access kind in configuration bits [5:4] qualifies accesses: 2'b01 loads only (`acc_write`=0), 2'b10 stores only (`acc_write`=1), 2'b00 and 2'b11 any access.
- R5: The selector in configuration bits [7:6] picks what must agree: 2'b00 the masked address only, 2'b01 the full data word only, 2'b10 and 2'b11 both.
- R6: Only cycles with `acc_valid` high are evaluated.
- R7: A hit sets status bit i, seen on `wp_match[i]`, at the first clock edge after the access. The bit stays set until it is cleared by a status write.
- R8: Writing 1 to status bit i clears it. If the same cycle carries a new hit for comparator i, the bit stays set. Bits written with 0 are unchanged.
- R9: `halt_req` is high exactly when at least one status bit is set.
- R10: Every register reads back on `cfg_rdata` in the same cycle at its offset. The configuration register returns only its 8 defined bits.
- R11: Comparators are evaluated independently, so one access can set several status bits at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Data access present this cycle |
| acc_addr | input | 32 | Data access address |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_data | input | 32 | Data loaded or stored |
| wp_match | output | 4 | Sticky per-comparator match status |
| halt_req | output | 1 | Halt request to the core |

## Verification
The status register can receive a write-one-to-clear from the debugger and a fresh hit from the load/store port in the same clock cycle. The bench drives a status clear and a matching access in one cycle, first for the same comparator and then for a different one. It then expects the bit with the fresh hit to remain set and only the other written bit to drop.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;

  localparam int MASK_W = 4;

  typedef enum logic [1:0] {
    KIND_ANY     = 2'b00,
    KIND_LOAD    = 2'b01,
    KIND_STORE   = 2'b10,
    KIND_ANY_ALT = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEL_ADDR     = 2'b00,
    SEL_DATA     = 2'b01,
    SEL_BOTH     = 2'b10,
    SEL_BOTH_ALT = 2'b11
  } match_sel_e;

  typedef enum logic [1:0] {
    RGN_MISC = 2'b00,
    RGN_ADDR = 2'b01,
    RGN_CFG  = 2'b10,
    RGN_DATA = 2'b11
  } region_e;

  // bit layout: sel [7:6], kind [5:4], mask [3:0]
  typedef struct packed {
    match_sel_e          sel;
    acc_kind_e           kind;
    logic [MASK_W-1:0]   mask;
  } cmp_cfg_t;

  localparam int CFG_BITS = $bits(cmp_cfg_t);

  function automatic logic kind_ok(input acc_kind_e kind, input logic is_write);
    case (kind)
      KIND_LOAD:  return !is_write;
      KIND_STORE: return is_write;
      default:    return 1'b1;
    endcase
  endfunction

  function automatic logic sel_ok(input match_sel_e sel, input logic a_ok, input logic d_ok);
    case (sel)
      SEL_ADDR: return a_ok;
      SEL_DATA: return d_ok;
      default:  return a_ok && d_ok;
    endcase
  endfunction

endpackage

// File: rtl/dwatch_regs.sv
module dwatch_regs
  import dwatch_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int REG_W   = 32,
  localparam int IDX_W  = $clog2(NUM_CMP),
  localparam int CA_W   = IDX_W + 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CA_W-1:0]               cfg_addr,
  input  logic [REG_W-1:0]              cfg_wdata,
  output logic [REG_W-1:0]              cfg_rdata,
  input  logic [NUM_CMP-1:0]            status,
  output logic [NUM_CMP-1:0]            cmp_en,
  output logic [NUM_CMP-1:0][AW-1:0]    ref_addr,
  output logic [NUM_CMP-1:0][DW-1:0]    ref_data,
  output cmp_cfg_t [NUM_CMP-1:0]        ref_cfg,
  output logic [NUM_CMP-1:0]            clr_vec
);

  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(1);

  region_e          region;
  logic [IDX_W-1:0] idx;

  assign region = region_e'(cfg_addr[CA_W-1 -: 2]);
  assign idx    = cfg_addr[IDX_W-1:0];

  assign clr_vec = (cfg_we && region == RGN_MISC && idx == IDX_STAT)
                   ? cfg_wdata[NUM_CMP-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_en   <= '0;
      ref_addr <= '0;
      ref_data <= '0;
      ref_cfg  <= '0;
    end else if (cfg_we) begin
      case (region)
        RGN_MISC: if (idx == IDX_CTRL) cmp_en <= cfg_wdata[NUM_CMP-1:0];
        RGN_ADDR: ref_addr[idx] <= cfg_wdata[AW-1:0];
        RGN_CFG:  ref_cfg[idx]  <= cmp_cfg_t'(cfg_wdata[CFG_BITS-1:0]);
        RGN_DATA: ref_data[idx] <= cfg_wdata[DW-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (region)
      RGN_MISC: begin
        if (idx == IDX_CTRL)      cfg_rdata = REG_W'(cmp_en);
        else if (idx == IDX_STAT) cfg_rdata = REG_W'(status);
      end
      RGN_ADDR: cfg_rdata = REG_W'(ref_addr[idx]);
      RGN_CFG:  cfg_rdata = REG_W'(ref_cfg[idx]);
      RGN_DATA: cfg_rdata = REG_W'(ref_data[idx]);
      default:  cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dwatch_cmp.sv
module dwatch_cmp
  import dwatch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic           enable,
  input  logic [AW-1:0]  ref_addr,
  input  logic [DW-1:0]  ref_data,
  input  cmp_cfg_t       cfg,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic           acc_write,
  input  logic [DW-1:0]  acc_data,
  output logic           hit
);

  // Address equality above the lowest n bits
  function automatic logic addr_match(input logic [AW-1:0] a,
                                      input logic [AW-1:0] b,
                                      input logic [MASK_W-1:0] n);
    return ((a ^ b) >> n) == '0;
  endfunction

  logic addr_ok, data_ok, kind_fit;

  always_comb begin
    addr_ok  = addr_match(acc_addr, ref_addr, cfg.mask);
    data_ok  = (acc_data == ref_data);
    kind_fit = kind_ok(cfg.kind, acc_write);
    hit      = enable && acc_valid && kind_fit && sel_ok(cfg.sel, addr_ok, data_ok);
  end

endmodule

// File: rtl/dwatch_status.sv
module dwatch_status #(
  parameter int NUM_CMP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMP-1:0] hit,
  input  logic [NUM_CMP-1:0] clr,
  output logic [NUM_CMP-1:0] status
);

  // A fresh hit outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr) | hit;
  end

endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
  import dwatch_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int REG_W   = 32,
  localparam int CA_W   = $clog2(NUM_CMP) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CA_W-1:0]    cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic               acc_valid,
  input  logic [AW-1:0]      acc_addr,
  input  logic               acc_write,
  input  logic [DW-1:0]      acc_data,
  output logic [NUM_CMP-1:0] wp_match,
  output logic               halt_req
);

  logic [NUM_CMP-1:0]          cmp_en;
  logic [NUM_CMP-1:0]          cmp_hit;
  logic [NUM_CMP-1:0]          clr_vec;
  logic [NUM_CMP-1:0][AW-1:0]  ref_addr;
  logic [NUM_CMP-1:0][DW-1:0]  ref_data;
  cmp_cfg_t [NUM_CMP-1:0]      ref_cfg;
  logic [NUM_CMP-1:0]          status;

  dwatch_regs #(
    .NUM_CMP(NUM_CMP), .AW(AW), .DW(DW), .REG_W(REG_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .status   (status),
    .cmp_en   (cmp_en),
    .ref_addr (ref_addr),
    .ref_data (ref_data),
    .ref_cfg  (ref_cfg),
    .clr_vec  (clr_vec)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    dwatch_cmp #(.AW(AW), .DW(DW)) u_cmp (
      .enable   (cmp_en[i]),
      .ref_addr (ref_addr[i]),
      .ref_data (ref_data[i]),
      .cfg      (ref_cfg[i]),
      .acc_valid(acc_valid),
      .acc_addr (acc_addr),
      .acc_write(acc_write),
      .acc_data (acc_data),
      .hit      (cmp_hit[i])
    );
  end

  dwatch_status #(.NUM_CMP(NUM_CMP)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (cmp_hit),
    .clr   (clr_vec),
    .status(status)
  );

  assign wp_match = status;
  assign halt_req = |status;

endmodule

// File: rtl/dwatch_unit_chk.sv
module dwatch_unit_chk #(
  parameter int NUM_CMP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic [NUM_CMP-1:0] cmp_en,
  input logic [NUM_CMP-1:0] cmp_hit,
  input logic [NUM_CMP-1:0] clr_vec,
  input logic [NUM_CMP-1:0] wp_match,
  input logic               halt_req
);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_chk
    assert_hit_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[i] |-> cmp_en[i]);

    assert_hit_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[i] |-> acc_valid);

    assert_hit_sets_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[i] |=> wp_match[i]);

    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_match[i] && !clr_vec[i]) |=> wp_match[i]);

    assert_rise_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wp_match[i]) |-> $past(cmp_hit[i]));

    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !cmp_hit[i]) |=> !wp_match[i]);
  end

  assert_halt_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(|cmp_hit));

  assert_halt_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_req) |-> ($past(|clr_vec) && !$past(|cmp_hit)));

endmodule

bind dwatch_unit dwatch_unit_chk #(.NUM_CMP(NUM_CMP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_valid(acc_valid),
  .cmp_en   (cmp_en),
  .cmp_hit  (cmp_hit),
  .clr_vec  (clr_vec),
  .wp_match (wp_match),
  .halt_req (halt_req)
);

// File: tb/dwatch_unit_tb.sv
module dwatch_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_data = '0;
  logic [3:0]  wp_match;
  logic        halt_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  dwatch_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write), .acc_data(acc_data),
    .wp_match(wp_match), .halt_req(halt_req)
  );

  localparam logic [3:0] O_CTRL = 4'h0, O_STAT = 4'h1;

  // One cycle of stimulus; returns at the following falling edge
  task automatic step(input logic we, input logic [3:0] a, input logic [31:0] wd,
                      input logic av, input logic [31:0] aa, input logic aw,
                      input logic [31:0] ad);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    acc_valid = av; acc_addr = aa; acc_write = aw; acc_data = ad;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic acc(input logic [31:0] aa, input logic aw, input logic [31:0] ad);
    step(1'b0, 4'h0, '0, 1'b1, aa, aw, ad);
  endtask

  task automatic chk_out(input logic [3:0] exp, input string req);
    logic exp_halt;
    exp_halt = |exp;
    checks++;
    if (wp_match !== exp || halt_req !== exp_halt) begin
      fails++;
      $display("FAIL %s: match=%b halt=%b expected match=%b halt=%b",
               req, wp_match, halt_req, exp, exp_halt);
    end
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      fails++;
      $display("FAIL %s: rdata[%h]=%h expected %h", req, a, cfg_rdata, exp);
    end
  endtask

  task automatic t_reset;
    chk_out(4'b0000, "R1");
    chk_rd(O_CTRL, 32'h0, "R1");
    chk_rd(O_STAT, 32'h0, "R1");
    chk_rd(4'h5, 32'h0, "R1");
    chk_rd(4'hB, 32'h0, "R1");
  endtask

  task automatic t_readback;  // R10
    wr(4'h6, 32'hDEADBEEF);
    chk_rd(4'h6, 32'hDEADBEEF, "R10");
    wr(4'h9, 32'hFFFF_FFA5);
    chk_rd(4'h9, 32'h0000_00A5, "R10");
    wr(4'hE, 32'h1234_5678);
    chk_rd(4'hE, 32'h1234_5678, "R10");
    wr(O_CTRL, 32'h5);
    chk_rd(O_CTRL, 32'h5, "R10");
    wr(O_CTRL, 32'h0);
  endtask

  task automatic t_enable;  // R2, R9
    wr(4'h4, 32'h1000);
    wr(4'h8, 32'h00);
    acc(32'h1000, 1'b0, '0);
    chk_out(4'b0000, "R2");
    wr(O_CTRL, 32'h1);
    acc(32'h1000, 1'b0, '0);
    chk_out(4'b0001, "R2");
  endtask

  task automatic t_sticky;  // R7, R8
    acc(32'h2000, 1'b0, '0);
    chk_out(4'b0001, "R7");
    wr(O_STAT, 32'h0);
    chk_out(4'b0001, "R8");
    wr(O_STAT, 32'h1);
    chk_out(4'b0000, "R8");
  endtask

  task automatic t_valid;  // R6
    step(1'b0, 4'h0, '0, 1'b0, 32'h1000, 1'b0, '0);
    chk_out(4'b0000, "R6");
  endtask

  task automatic t_mask;  // R3
    wr(4'h5, 32'h2000);
    wr(4'h9, 32'h08);
    wr(O_CTRL, 32'h3);
    acc(32'h20FF, 1'b1, '0);
    chk_out(4'b0010, "R3");
    wr(O_STAT, 32'h2);
    acc(32'h2100, 1'b1, '0);
    chk_out(4'b0000, "R3");
    acc(32'h1FFF, 1'b0, '0);
    chk_out(4'b0000, "R3");
    acc(32'h1001, 1'b0, '0);  // comparator 0 is exact
    chk_out(4'b0000, "R3");
    wr(4'h9, 32'h0F);
    acc(32'h7FFC, 1'b0, '0);
    chk_out(4'b0010, "R3");
    wr(O_STAT, 32'h2);
    acc(32'h8000, 1'b0, '0);
    chk_out(4'b0000, "R3");
    wr(O_CTRL, 32'h1);
  endtask

  task automatic t_kind;  // R4
    wr(4'h8, 32'h10);
    acc(32'h1000, 1'b1, '0);
    chk_out(4'b0000, "R4");
    acc(32'h1000, 1'b0, '0);
    chk_out(4'b0001, "R4");
    wr(O_STAT, 32'h1);
    wr(4'h8, 32'h20);
    acc(32'h1000, 1'b0, '0);
    chk_out(4'b0000, "R4");
    acc(32'h1000, 1'b1, '0);
    chk_out(4'b0001, "R4");
    wr(O_STAT, 32'h1);
    wr(4'h8, 32'h30);
    acc(32'h1000, 1'b1, '0);
    chk_out(4'b0001, "R4");
    wr(O_STAT, 32'h1);
  endtask

  task automatic t_select;  // R5
    wr(4'hC, 32'hCAFE);
    wr(4'h8, 32'h40);
    acc(32'h5555, 1'b1, 32'hCAFE);
    chk_out(4'b0001, "R5");
    wr(O_STAT, 32'h1);
    acc(32'h1000, 1'b1, 32'hBEEF);
    chk_out(4'b0000, "R5");
    wr(4'h8, 32'h80);
    acc(32'h1004, 1'b0, 32'hCAFE);
    chk_out(4'b0000, "R5");
    acc(32'h1000, 1'b0, 32'h0);
    chk_out(4'b0000, "R5");
    acc(32'h1000, 1'b0, 32'hCAFE);
    chk_out(4'b0001, "R5");
    wr(O_STAT, 32'h1);
    wr(4'h8, 32'hC0);
    acc(32'h1000, 1'b0, 32'hCAFF);
    chk_out(4'b0000, "R5");
  endtask

  task automatic t_collide;  // R8: clear and hit in one cycle
    wr(4'h8, 32'h00);
    wr(4'h9, 32'h00);
    wr(O_CTRL, 32'h3);
    acc(32'h1000, 1'b0, '0);
    chk_out(4'b0001, "R8");
    step(1'b1, O_STAT, 32'h1, 1'b1, 32'h1000, 1'b0, '0);
    chk_out(4'b0001, "R8");
    step(1'b1, O_STAT, 32'h1, 1'b1, 32'h2000, 1'b1, '0);
    chk_out(4'b0010, "R8");
    wr(O_STAT, 32'h2);
    chk_out(4'b0000, "R8");
  endtask

  task automatic t_multi;  // R11
    wr(4'h6, 32'h3000);
    wr(4'hA, 32'h0C);
    wr(4'h7, 32'h3F00);
    wr(4'hB, 32'h08);
    wr(O_CTRL, 32'hC);
    acc(32'h3F10, 1'b0, '0);
    chk_out(4'b1100, "R11");
    chk_rd(O_STAT, 32'hC, "R11");
    wr(O_STAT, 32'hC);
    acc(32'h3010, 1'b1, '0);
    chk_out(4'b0100, "R11");
    wr(O_STAT, 32'hF);
    chk_out(4'b0000, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_enable();
    t_sticky();
    t_valid();
    t_mask();
    t_kind();
    t_select();
    t_collide();
    t_multi();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule